// File: doc/BRIEF.md
# Register Pair and Stack Sequencer

This block keeps the 16-bit register pairs of a small 8-bit datapath: three general pairs built from six byte registers, an accumulator-and-flags pair, and a 16-bit stack pointer. A command port starts one operation at a time. The operation may move bytes between a pair and memory, exchange pairs, or do 16-bit arithmetic on a pair. Memory is reached through a byte-wide synchronous port. Read data comes back in the clock after the read strobe. The block makes one access per clock and ends every command with a one-cycle `done` pulse.

An instruction sequencer sits upstream. It drives `cmd_valid` with an opcode, a pair code and an immediate while `busy` is low, then waits for `done`. The pair values and the stack pointer are driven out continuously, so the surrounding datapath can use them. A command's results appear on those outputs from the cycle after `done`.

Top module: `rps_sequencer`

## Requirements
- R1: A synchronous active-high `rst` clears all four pairs and the stack pointer to zero. While reset is held and after it is released, `busy`, `done`, `mem_rd` and `mem_wr` are low.
- R2: A command is taken only when `cmd_valid` is high and `busy` is low. `cmd_valid` while busy changes nothing. Opcodes are 1 push, 2 pop, 3 swap HL with stack top, 4 swap HL with DE, 5 HL to SP, 6 load HL direct, 7 store HL direct, 8 add pair to HL, 9 increment pair, 10 decrement pair. Any other code completes after one busy cycle and changes nothing.
- R3: `mem_rd` and `mem_wr` are never high together. Access counts are: two for push, pop, load direct and store direct; four for the stack-top swap; none for the other commands.
- R4: `done` is high for exactly one cycle. It comes in the cycle after the last memory access, or after the single execute cycle of a command with no access. `busy` falls with it, and results are visible from the next cycle.
- R5: Push, with pair code 0 BC, 1 DE, 2 HL, 3 accumulator (high) and flags (low), writes the high byte to SP-1 and then the low byte to SP-2. SP ends two lower.
- R6: Pop (same pair codes as push) reads [SP] into the low byte and [SP+1] into the high byte. SP ends two higher.
- R7: The stack-top swap exchanges L with [SP] and H with [SP+1]. SP is unchanged.
- R8: Load direct puts [imm] into L and [imm+1] into H. Store direct writes L to imm and H to imm+1, and leaves HL unchanged.
- R9: HL-to-SP copies H to the high byte and L to the low byte of SP. HL is unchanged.
- R10: The add puts HL + pair into HL, where pair code 3 selects SP. It sets flags bit 0 (carry) when the sum passes 16 bits and clears it otherwise. The other flag bits are unchanged.
- R11: The DE swap exchanges D with H and E with L, with no memory access.
- R12: Increment and decrement of a pair (code 3 selects SP) wrap modulo 65536 and leave the flags unchanged.
- R13: Stack and direct addresses wrap modulo 65536. A push at SP 0000h writes FFFFh and FFFEh, and a direct load at FFFFh takes H from 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 4 | Opcode |
| cmd_pair | input | 2 | Pair code |
| cmd_imm | input | 16 | Direct address for load/store |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| pair_bc | output | 16 | B (high) and C (low) |
| pair_de | output | 16 | D (high) and E (low) |
| pair_hl | output | 16 | H (high) and L (low) |
| pair_af | output | 16 | Accumulator (high) and flags (low) |
| sp_q | output | 16 | Stack pointer |

## Verification
Some rules are checked by assertions on every clock. These are the exclusive strobes and the single-cycle done pulse. They also cover the SP offset on push and pop and the unchanged SP after a stack-top swap. The flags must be held apart from the carry on an add and held entirely on increment and decrement. The DE swap and the HL copy into SP are checked the same way. Byte order in memory, the modulo wrap of addresses and the swap through memory are only visible in the bench's scenarios, as are commands ignored while busy and unknown opcodes. There, a reference model of the registers and memory is compared after each command.

// File: rtl/rps_pkg.sv
package rps_pkg;

   typedef enum logic [3:0] {
      OP_NONE  = 4'd0,
      OP_PUSH  = 4'd1,
      OP_POP   = 4'd2,
      OP_XSTK  = 4'd3,
      OP_XDH   = 4'd4,
      OP_HL2SP = 4'd5,
      OP_LDHL  = 4'd6,
      OP_STHL  = 4'd7,
      OP_ADD   = 4'd8,
      OP_INC   = 4'd9,
      OP_DEC   = 4'd10
   } rps_op_e;

   localparam int IX_BC = 0;
   localparam int IX_DE = 1;
   localparam int IX_HL = 2;
   localparam int IX_AF = 3;
   localparam int NUM_PAIRS = 4;

   // index of the final run step of a command
   function automatic logic [2:0] last_step(input logic [3:0] op);
      case (op)
         OP_PUSH, OP_POP, OP_LDHL, OP_STHL: last_step = 3'd1;
         OP_XSTK:                           last_step = 3'd3;
         default:                           last_step = 3'd0;
      endcase
   endfunction

   function automatic logic uses_mem(input logic [3:0] op);
      case (op)
         OP_PUSH, OP_POP, OP_XSTK, OP_LDHL, OP_STHL: uses_mem = 1'b1;
         default:                                   uses_mem = 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/rps_alu16.sv
module rps_alu16 #(
   parameter int AW       = 16,
   parameter bit WIDE_ADD = 1'b1
) (
   input  logic [AW-1:0] a,
   input  logic [AW-1:0] b,
   input  logic          dec,
   output logic [AW-1:0] sum,
   output logic          carry,
   output logic [AW-1:0] step_res
);

   generate
      if (WIDE_ADD) begin : g_wide
         logic [AW:0] full;
         assign full  = {1'b0, a} + {1'b0, b};
         assign sum   = full[AW-1:0];
         assign carry = full[AW];
      end else begin : g_msb
         // carry out recovered from operand and result sign bits
         assign sum   = a + b;
         assign carry = (a[AW-1] & b[AW-1]) | ((a[AW-1] | b[AW-1]) & ~sum[AW-1]);
      end
   endgenerate

   assign step_res = dec ? (b - AW'(1)) : (b + AW'(1));

endmodule

// File: rtl/rps_seq.sv
module rps_seq
   import rps_pkg::*;
#(
   parameter int DW = 8,
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          cmd_valid,
   input  logic [3:0]    cmd_op,
   input  logic [1:0]    cmd_pair,
   input  logic [AW-1:0] cmd_imm,
   input  logic [AW-1:0] sp,
   input  logic [AW-1:0] hl,
   input  logic [AW-1:0] sel,
   input  logic [DW-1:0] mem_rdata,
   output logic          busy,
   output logic          fin,
   output logic [3:0]    op_q,
   output logic [1:0]    pair_q,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   output logic          mem_rd,
   output logic          mem_wr,
   output logic [DW-1:0] temp_lo,
   output logic [DW-1:0] temp_hi
);

   typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} st_e;

   st_e           state;
   logic [2:0]    step;
   logic [AW-1:0] imm_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state   <= ST_IDLE;
         step    <= 3'd0;
         op_q    <= 4'd0;
         pair_q  <= 2'd0;
         imm_q   <= '0;
         temp_lo <= '0;
         temp_hi <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (cmd_valid) begin
                  op_q   <= cmd_op;
                  pair_q <= cmd_pair;
                  imm_q  <= cmd_imm;
                  step   <= 3'd0;
                  state  <= ST_RUN;
               end
            end
            ST_RUN: begin
               if (step == 3'd1 && (op_q == OP_POP || op_q == OP_XSTK || op_q == OP_LDHL))
                  temp_lo <= mem_rdata;
               if (step == 3'd2 && op_q == OP_XSTK)
                  temp_hi <= mem_rdata;
               if (step == last_step(op_q)) state <= ST_FIN;
               else                         step  <= step + 3'd1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_rd    = 1'b0;
      mem_wr    = 1'b0;
      mem_addr  = sp;
      mem_wdata = '0;
      if (state == ST_RUN) begin
         case (op_q)
            OP_PUSH: begin
               mem_wr    = 1'b1;
               mem_addr  = step[0] ? (sp - AW'(2)) : (sp - AW'(1));
               mem_wdata = step[0] ? sel[DW-1:0] : sel[AW-1:DW];
            end
            OP_POP: begin
               mem_rd   = 1'b1;
               mem_addr = step[0] ? (sp + AW'(1)) : sp;
            end
            OP_XSTK: begin
               mem_rd    = ~step[1];
               mem_wr    = step[1];
               mem_addr  = step[0] ? (sp + AW'(1)) : sp;
               mem_wdata = step[0] ? hl[AW-1:DW] : hl[DW-1:0];
            end
            OP_LDHL: begin
               mem_rd   = 1'b1;
               mem_addr = step[0] ? (imm_q + AW'(1)) : imm_q;
            end
            OP_STHL: begin
               mem_wr    = 1'b1;
               mem_addr  = step[0] ? (imm_q + AW'(1)) : imm_q;
               mem_wdata = step[0] ? hl[AW-1:DW] : hl[DW-1:0];
            end
            default: ;
         endcase
      end
   end

   assign busy = (state != ST_IDLE);
   assign fin  = (state == ST_FIN);

   p_one_access_r3: assert property (@(posedge clk) disable iff (rst)
      !(mem_rd && mem_wr));
   p_strobe_in_run_r3: assert property (@(posedge clk) disable iff (rst)
      (mem_rd || mem_wr) |-> (busy && !fin));
   p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
      fin |=> !fin);
   p_done_after_access_r4: assert property (@(posedge clk) disable iff (rst)
      (fin && uses_mem(op_q)) |-> $past(mem_rd || mem_wr));
   p_ignore_busy_r2: assert property (@(posedge clk) disable iff (rst)
      (busy && cmd_valid) |=> ($stable(op_q) && $stable(pair_q) && $stable(imm_q)));

endmodule

// File: rtl/rps_regs.sv
module rps_regs
   import rps_pkg::*;
#(
   parameter int DW     = 8,
   parameter int CY_POS = 0
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            fin,
   input  logic [3:0]      op_q,
   input  logic [1:0]      pair_q,
   input  logic [DW-1:0]   temp_lo,
   input  logic [DW-1:0]   temp_hi,
   input  logic [DW-1:0]   mem_rdata,
   input  logic [2*DW-1:0] sum,
   input  logic            carry,
   input  logic [2*DW-1:0] step_res,
   output logic [2*DW-1:0] pair_bc,
   output logic [2*DW-1:0] pair_de,
   output logic [2*DW-1:0] pair_hl,
   output logic [2*DW-1:0] pair_af,
   output logic [2*DW-1:0] sp_q,
   output logic [2*DW-1:0] sel_push,
   output logic [2*DW-1:0] src16
);

   localparam int PW = 2 * DW;
   localparam logic [DW-1:0] KEEP_MASK = ~(DW'(1) << CY_POS);

   logic [PW-1:0] pr_q [NUM_PAIRS];
   logic [PW-1:0] nxt  [NUM_PAIRS];
   logic [PW-1:0] sp_d;

   always_comb begin
      for (int i = 0; i < NUM_PAIRS; i++) begin
         nxt[i] = pr_q[i];
         if (fin) begin
            case (op_q)
               OP_POP:  if (pair_q == 2'(i)) nxt[i] = {mem_rdata, temp_lo};
               OP_INC, OP_DEC:
                  if (pair_q == 2'(i) && i != IX_AF) nxt[i] = step_res;
               OP_LDHL: if (i == IX_HL) nxt[i] = {mem_rdata, temp_lo};
               OP_XSTK: if (i == IX_HL) nxt[i] = {temp_hi, temp_lo};
               OP_ADD: begin
                  if (i == IX_HL) nxt[i] = sum;
                  if (i == IX_AF) nxt[i][CY_POS] = carry;
               end
               OP_XDH: begin
                  if (i == IX_HL) nxt[i] = pr_q[IX_DE];
                  if (i == IX_DE) nxt[i] = pr_q[IX_HL];
               end
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      sp_d = sp_q;
      if (fin) begin
         case (op_q)
            OP_PUSH:        sp_d = sp_q - PW'(2);
            OP_POP:         sp_d = sp_q + PW'(2);
            OP_HL2SP:       sp_d = pr_q[IX_HL];
            OP_INC, OP_DEC: if (pair_q == 2'(IX_AF)) sp_d = step_res;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < NUM_PAIRS; i++) pr_q[i] <= '0;
         sp_q <= '0;
      end else begin
         for (int i = 0; i < NUM_PAIRS; i++) pr_q[i] <= nxt[i];
         sp_q <= sp_d;
      end
   end

   assign pair_bc  = pr_q[IX_BC];
   assign pair_de  = pr_q[IX_DE];
   assign pair_hl  = pr_q[IX_HL];
   assign pair_af  = pr_q[IX_AF];
   assign sel_push = pr_q[pair_q];
   assign src16    = (pair_q == 2'(IX_AF)) ? sp_q : pr_q[pair_q];

   p_push_sp_r5: assert property (@(posedge clk) disable iff (rst)
      (fin && op_q == OP_PUSH) |=> (sp_q == $past(sp_q) - PW'(2)));
   p_pop_sp_r6: assert property (@(posedge clk) disable iff (rst)
      (fin && op_q == OP_POP) |=> (sp_q == $past(sp_q) + PW'(2)));
   p_xstk_sp_r7: assert property (@(posedge clk) disable iff (rst)
      (fin && op_q == OP_XSTK) |=> $stable(sp_q));
   p_store_keep_r8: assert property (@(posedge clk) disable iff (rst)
      (fin && op_q == OP_STHL) |=> $stable(pair_hl));
   p_hl2sp_r9: assert property (@(posedge clk) disable iff (rst)
      (fin && op_q == OP_HL2SP) |=> (sp_q == $past(pair_hl) && $stable(pair_hl)));
   p_add_flags_r10: assert property (@(posedge clk) disable iff (rst)
      (fin && op_q == OP_ADD) |=> ((pair_af[DW-1:0] & KEEP_MASK) == ($past(pair_af[DW-1:0]) & KEEP_MASK)));
   p_xdh_r11: assert property (@(posedge clk) disable iff (rst)
      (fin && op_q == OP_XDH) |=> (pair_hl == $past(pair_de) && pair_de == $past(pair_hl)));
   p_incdec_flags_r12: assert property (@(posedge clk) disable iff (rst)
      (fin && (op_q == OP_INC || op_q == OP_DEC)) |=> $stable(pair_af));

endmodule

// File: rtl/rps_sequencer.sv
module rps_sequencer
   import rps_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 16,
   parameter int CY_POS   = 0,
   parameter bit WIDE_ADD = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cmd_valid,
   input  logic [3:0]        cmd_op,
   input  logic [1:0]        cmd_pair,
   input  logic [ADDR_W-1:0] cmd_imm,
   output logic              busy,
   output logic              done,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_rd,
   output logic              mem_wr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] pair_bc,
   output logic [ADDR_W-1:0] pair_de,
   output logic [ADDR_W-1:0] pair_hl,
   output logic [ADDR_W-1:0] pair_af,
   output logic [ADDR_W-1:0] sp_q
);

   localparam int PW = 2 * DATA_W;

   generate
      if (ADDR_W != PW) begin : g_bad_width
         $error("rps_sequencer: ADDR_W must be twice DATA_W");
      end
      if (CY_POS < 0 || CY_POS >= DATA_W) begin : g_bad_cy
         $error("rps_sequencer: CY_POS outside the flag byte");
      end
   endgenerate

   logic [3:0]        op_q;
   logic [1:0]        pair_q;
   logic [DATA_W-1:0] temp_lo, temp_hi;
   logic [PW-1:0]     sel_push, src16, sum, step_res;
   logic              carry;

   rps_seq #(.DW(DATA_W), .AW(ADDR_W)) seq_i (
      .clk       (clk),
      .rst       (rst),
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .cmd_pair  (cmd_pair),
      .cmd_imm   (cmd_imm),
      .sp        (sp_q),
      .hl        (pair_hl),
      .sel       (sel_push),
      .mem_rdata (mem_rdata),
      .busy      (busy),
      .fin       (done),
      .op_q      (op_q),
      .pair_q    (pair_q),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rd    (mem_rd),
      .mem_wr    (mem_wr),
      .temp_lo   (temp_lo),
      .temp_hi   (temp_hi)
   );

   rps_alu16 #(.AW(PW), .WIDE_ADD(WIDE_ADD)) alu_i (
      .a        (pair_hl),
      .b        (src16),
      .dec      (op_q == OP_DEC),
      .sum      (sum),
      .carry    (carry),
      .step_res (step_res)
   );

   rps_regs #(.DW(DATA_W), .CY_POS(CY_POS)) regs_i (
      .clk       (clk),
      .rst       (rst),
      .fin       (done),
      .op_q      (op_q),
      .pair_q    (pair_q),
      .temp_lo   (temp_lo),
      .temp_hi   (temp_hi),
      .mem_rdata (mem_rdata),
      .sum       (sum),
      .carry     (carry),
      .step_res  (step_res),
      .pair_bc   (pair_bc),
      .pair_de   (pair_de),
      .pair_hl   (pair_hl),
      .pair_af   (pair_af),
      .sp_q      (sp_q),
      .sel_push  (sel_push),
      .src16     (src16)
   );

endmodule

// File: tb/rps_sequencer_tb.sv
module rps_sequencer_tb_top;
   import rps_pkg::*;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cmd_valid = 1'b0;
   logic [3:0]  cmd_op = 4'd0;
   logic [1:0]  cmd_pair = 2'd0;
   logic [15:0] cmd_imm = 16'd0;
   logic        busy, done, mem_rd, mem_wr;
   logic [15:0] mem_addr, pair_bc, pair_de, pair_hl, pair_af, sp_q;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata = 8'd0;

   logic [7:0]  mem     [65536];
   logic [7:0]  ref_mem [65536];
   logic [15:0] m_pr [4];
   logic [15:0] m_sp;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   rps_sequencer dut_i (
      .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_pair(cmd_pair), .cmd_imm(cmd_imm), .busy(busy), .done(done),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd),
      .mem_wr(mem_wr), .mem_rdata(mem_rdata), .pair_bc(pair_bc),
      .pair_de(pair_de), .pair_hl(pair_hl), .pair_af(pair_af), .sp_q(sp_q)
   );

   always @(posedge clk) begin
      if (mem_wr) mem[mem_addr] = mem_wdata;
      if (mem_rd) mem_rdata <= mem[mem_addr];
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic string req_of(input logic [3:0] op);
      case (op)
         OP_PUSH:          return "R5";
         OP_POP:           return "R6";
         OP_XSTK:          return "R7";
         OP_LDHL, OP_STHL: return "R8";
         OP_HL2SP:         return "R9";
         OP_ADD:           return "R10";
         OP_XDH:           return "R11";
         OP_INC, OP_DEC:   return "R12";
         default:          return "R2";
      endcase
   endfunction

   function automatic int exp_busy(input logic [3:0] op);
      case (op)
         OP_PUSH, OP_POP, OP_LDHL, OP_STHL: return 2;
         OP_XSTK:                           return 4;
         default:                           return 1;
      endcase
   endfunction

   function automatic int exp_acc(input logic [3:0] op);
      case (op)
         OP_PUSH, OP_POP, OP_LDHL, OP_STHL: return 2;
         OP_XSTK:                           return 4;
         default:                           return 0;
      endcase
   endfunction

   task automatic model_apply(input logic [3:0] op, input logic [1:0] pr,
                              input logic [15:0] imm, output int nw,
                              output logic [15:0] wa0, output logic [15:0] wa1);
      logic [15:0] t, a0, a1;
      logic [16:0] s;
      nw = 0; wa0 = 16'd0; wa1 = 16'd0;
      a0 = m_sp; a1 = m_sp + 16'd1;
      case (op)
         OP_PUSH: begin
            wa0 = m_sp - 16'd1; wa1 = m_sp - 16'd2; nw = 2;
            ref_mem[wa0] = m_pr[pr][15:8];
            ref_mem[wa1] = m_pr[pr][7:0];
            m_sp = m_sp - 16'd2;
         end
         OP_POP: begin
            m_pr[pr] = {ref_mem[a1], ref_mem[a0]};
            m_sp = m_sp + 16'd2;
         end
         OP_XSTK: begin
            t = {ref_mem[a1], ref_mem[a0]};
            ref_mem[a0] = m_pr[2][7:0];
            ref_mem[a1] = m_pr[2][15:8];
            wa0 = a0; wa1 = a1; nw = 2;
            m_pr[2] = t;
         end
         OP_XDH: begin
            t = m_pr[2]; m_pr[2] = m_pr[1]; m_pr[1] = t;
         end
         OP_HL2SP: m_sp = m_pr[2];
         OP_LDHL: begin
            t = imm + 16'd1;
            m_pr[2] = {ref_mem[t], ref_mem[imm]};
         end
         OP_STHL: begin
            wa0 = imm; wa1 = imm + 16'd1; nw = 2;
            ref_mem[wa0] = m_pr[2][7:0];
            ref_mem[wa1] = m_pr[2][15:8];
         end
         OP_ADD: begin
            t = (pr == 2'd3) ? m_sp : m_pr[pr];
            s = {1'b0, m_pr[2]} + {1'b0, t};
            m_pr[2] = s[15:0];
            m_pr[3][0] = s[16];
         end
         OP_INC, OP_DEC: begin
            if (pr == 2'd3) m_sp = (op == OP_INC) ? m_sp + 16'd1 : m_sp - 16'd1;
            else m_pr[pr] = (op == OP_INC) ? m_pr[pr] + 16'd1 : m_pr[pr] - 16'd1;
         end
         default: ;
      endcase
   endtask

   task automatic run_cmd(input logic [3:0] op, input logic [1:0] pr,
                          input logic [15:0] imm, input bit junk);
      int cnt, acc, both, nw;
      logic [15:0] wa0, wa1;
      string rq;
      rq = req_of(op);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_pair = pr; cmd_imm = imm;
      cnt = 0; acc = 0; both = 0;
      do begin
         @(negedge clk);
         cnt++;
         if (mem_rd || mem_wr) acc++;
         if (mem_rd && mem_wr) both++;
         if (cnt == 1) begin
            if (junk) begin
               // different command offered while busy: must be ignored (R2)
               cmd_op = OP_INC; cmd_pair = 2'd0; cmd_imm = ~imm;
            end else cmd_valid = 1'b0;
         end
      end while (!done && cnt < 20);
      cmd_valid = 1'b0;
      model_apply(op, pr, imm, nw, wa0, wa1);
      chk("R4", {rq, " done latency"}, 32'(cnt), 32'(exp_busy(op) + 1));
      chk("R3", {rq, " access count"}, 32'(acc), 32'(exp_acc(op)));
      chk("R3", "strobes together", 32'(both), 32'd0);
      @(negedge clk);
      chk("R4", "done cleared", {31'd0, done}, 32'd0);
      chk("R4", "busy cleared", {31'd0, busy}, 32'd0);
      chk(junk ? "R2" : rq, "pair BC", 32'(pair_bc), 32'(m_pr[0]));
      chk(rq, "pair DE", 32'(pair_de), 32'(m_pr[1]));
      chk(rq, "pair HL", 32'(pair_hl), 32'(m_pr[2]));
      chk(rq, "pair AF", 32'(pair_af), 32'(m_pr[3]));
      chk(rq, "SP", 32'(sp_q), 32'(m_sp));
      if (nw > 0) begin
         chk(rq, "mem first byte", 32'(mem[wa0]), 32'(ref_mem[wa0]));
         chk(rq, "mem second byte", 32'(mem[wa1]), 32'(ref_mem[wa1]));
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      logic [3:0] op;
      int x;
      void'($urandom(32'h5eed_1234));
      for (int a = 0; a < 65536; a++) begin
         mem[a] = 8'($urandom);
         ref_mem[a] = mem[a];
      end
      for (int i = 0; i < 4; i++) m_pr[i] = 16'd0;
      m_sp = 16'd0;
      repeat (3) @(negedge clk);
      chk("R1", "busy in reset", {31'd0, busy}, 32'd0);
      rst = 1'b0;
      @(negedge clk);
      chk("R1", "BC after reset", 32'(pair_bc), 32'd0);
      chk("R1", "DE after reset", 32'(pair_de), 32'd0);
      chk("R1", "HL after reset", 32'(pair_hl), 32'd0);
      chk("R1", "AF after reset", 32'(pair_af), 32'd0);
      chk("R1", "SP after reset", 32'(sp_q), 32'd0);
      chk("R1", "done/strobes after reset", {29'd0, done, mem_rd, mem_wr}, 32'd0);

      // R12 wrap and R10 carry set then clear
      run_cmd(OP_DEC, 2'd2, 16'd0, 1'b0);
      chk("R12", "HL wrapped down", 32'(pair_hl), 32'h0000_FFFF);
      run_cmd(OP_INC, 2'd1, 16'd0, 1'b0);
      run_cmd(OP_ADD, 2'd1, 16'd0, 1'b0);
      chk("R10", "carry set on overflow", {31'd0, pair_af[0]}, 32'd1);
      chk("R10", "HL sum wrapped", 32'(pair_hl), 32'd0);
      run_cmd(OP_ADD, 2'd0, 16'd0, 1'b0);
      chk("R10", "carry cleared", {31'd0, pair_af[0]}, 32'd0);
      run_cmd(OP_DEC, 2'd0, 16'd0, 1'b0);
      run_cmd(OP_INC, 2'd0, 16'd0, 1'b0);
      chk("R12", "BC wrapped up", 32'(pair_bc), 32'd0);

      // R13: push at SP 0000 lands at FFFF/FFFE
      run_cmd(OP_PUSH, 2'd1, 16'd0, 1'b0);
      chk("R13", "byte at FFFF", 32'(mem[16'hFFFF]), 32'h00);
      chk("R13", "byte at FFFE", 32'(mem[16'hFFFE]), 32'h01);
      chk("R13", "SP after wrap push", 32'(sp_q), 32'h0000_FFFE);

      // load all pairs from memory
      for (int p = 0; p < 4; p++) run_cmd(OP_POP, 2'(p), 16'd0, 1'b0);
      run_cmd(OP_PUSH, 2'd3, 16'd0, 1'b1);
      run_cmd(OP_POP, 2'd2, 16'd0, 1'b1);
      run_cmd(4'd13, 2'd1, 16'h1234, 1'b0);
      run_cmd(OP_NONE, 2'd2, 16'h0, 1'b0);
      run_cmd(OP_XSTK, 2'd0, 16'd0, 1'b0);
      run_cmd(OP_XDH, 2'd0, 16'd0, 1'b0);
      run_cmd(OP_HL2SP, 2'd0, 16'd0, 1'b0);
      run_cmd(OP_XSTK, 2'd0, 16'd0, 1'b0);
      run_cmd(OP_LDHL, 2'd0, 16'hFFFF, 1'b0);
      chk("R13", "direct load high byte wraps", 32'(pair_hl[15:8]), 32'(mem[16'h0000]));
      run_cmd(OP_STHL, 2'd0, 16'hFFFF, 1'b0);
      run_cmd(OP_ADD, 2'd2, 16'd0, 1'b0);
      run_cmd(OP_ADD, 2'd3, 16'd0, 1'b0);
      run_cmd(OP_INC, 2'd3, 16'd0, 1'b0);
      run_cmd(OP_DEC, 2'd3, 16'd0, 1'b0);

      // constrained random mix
      for (int n = 0; n < 500; n++) begin
         x = int'($urandom % 12);
         op = (x == 11) ? 4'(11 + ($urandom % 5)) : 4'(x);
         run_cmd(op, 2'($urandom), 16'($urandom), ($urandom % 8) == 0);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule